// File: doc/BRIEF.md
# Uniform-Access Word Load/Store Stage

This block is the memory stage of a small 32-bit datapath. It takes an instruction word together with the two register values that the instruction names. It computes a word address and moves one word between a synchronous data RAM and the register file. The RAM and the register file are both outside the block. The stage is built so that the sequence of accesses it makes looks the same for a load, a store and any other instruction.

When the stage is active, every instruction gets one RAM read in its first cycle and one RAM write in its second cycle. It also gets one register read when it is accepted and one register write in the second cycle. A load writes the RAM word back unchanged. A store puts the old register value back into its register. Any other opcode writes back both values it read.

Two hint flags, sampled with the instruction, say whether a load or a store could occur in this step. When both are clear, the stage makes no access at all. A halted input blocks every memory and register update. Each instruction takes exactly two cycles, and the stage pulses a done flag at the end.

Top module: `uniform_mem_stage`

## Requirements
- R1: The word address is bits [AW+1:2] of (value of register rs + sign-extended imm), where AW = log2(DEPTH). The rs index is taken from instruction bits 25:21 and imm from bits 15:0. The address goes out on mem_addr in both access cycles.
- R2: With opcode 6'b100011 (load) in bits 31:26, register rt (bits 20:16) receives the RAM word at the address, and the RAM word is written back with its own value.
- R3: With opcode 6'b101011 (store), the RAM word at the address receives the value of register rt, and register rt is written back with its old value.
- R4: When active, every instruction, whatever its opcode, makes exactly one RAM read (mem_re in the cycle after acceptance) and one RAM write (mem_we in the cycle after that), and these two never occur in the same cycle. An opcode that is neither load nor store leaves both the RAM and the registers unchanged in value.
- R5: When may_load and may_store are both 0 at acceptance, the instruction makes no RAM read, no RAM write and no register write, but done still pulses.
- R6: If halted is 1 at acceptance, the instruction makes no access at all. If halted is 1 during the write cycle, neither mem_we nor rf_we is asserted.
- R7: A register write is never issued to register 0 (rf_we stays 0 when rt is 0).
- R8: done is 1 for exactly one cycle, the second cycle after start is sampled. start is accepted in any cycle except the read cycle, and a start during the read cycle is ignored. Back-to-back instructions can therefore issue every two cycles.
- R9: After reset, mem_re, mem_we, rf_we and done are all 0.
- R10: An effective address beyond the RAM depth wraps modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Presents an instruction this cycle |
| instr | input | 32 | Instruction word |
| halted | input | 1 | Program has terminated; blocks all updates |
| may_load | input | 1 | A load is possible in this step |
| may_store | input | 1 | A store is possible in this step |
| rf_rs_idx | output | 5 | Register file read index for the base register |
| rf_rt_idx | output | 5 | Register file read index for the data register |
| rf_rs_val | input | 32 | Base register value (combinational read) |
| rf_rt_val | input | 32 | Data register value (combinational read) |
| mem_re | output | 1 | RAM read strobe |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | AW | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, valid the cycle after mem_re |
| rf_we | output | 1 | Register file write enable |
| rf_widx | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| done | output | 1 | Instruction complete |

## Verification
The hardest case to reach is halted rising between the read cycle and the write cycle of an instruction that was accepted as active. In that case the read has already happened, and only the write must be blocked. The bench raises halted on the falling edge that opens the write cycle and checks that both write strobes are low. It then confirms that the targeted RAM word still holds its earlier value. A second hard case is start held high across four cycles. Only two of those cycles may be accepted, and the bench counts read strobes and done pulses to check that.

// File: rtl/ums_pkg.sv
package ums_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;
  localparam int OP_W   = 6;
  localparam int IMM_W  = 16;

  localparam logic [OP_W-1:0] OPC_LOAD_WORD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE_WORD = 6'b101011;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;
endpackage

// File: rtl/ums_decode.sv
module ums_decode
  import ums_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   base_val,
  output logic [RIDX_W-1:0] rs_idx,
  output logic [RIDX_W-1:0] rt_idx,
  output logic              is_load,
  output logic              is_store,
  output logic [AW-1:0]     word_addr
);
  logic [OP_W-1:0]  opcode;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  imm_sx;
  logic [XLEN-1:0]  eff_addr;
  logic             unused_ea_bits;

  assign opcode   = instr[31:26];
  assign rs_idx   = instr[25:21];
  assign rt_idx   = instr[20:16];
  assign imm      = instr[15:0];
  assign imm_sx   = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign eff_addr = base_val + imm_sx;

  // word granularity, upper bits dropped so addresses wrap modulo the depth
  assign word_addr      = eff_addr[AW+1:2];
  assign unused_ea_bits = ^{eff_addr[XLEN-1:AW+2], eff_addr[1:0]};

  assign is_load  = (opcode == OPC_LOAD_WORD);
  assign is_store = (opcode == OPC_STORE_WORD);
endmodule

// File: rtl/ums_ctrl.sv
module ums_ctrl
  import ums_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic halted,
  input  logic may_load,
  input  logic may_store,
  output logic capture,
  output logic rd_phase,
  output logic wr_phase,
  output logic done
);
  phase_e ph_q;
  logic   act_q;
  logic   go;

  assign capture = start && (ph_q != PH_READ);
  assign go      = !halted && (may_load || may_store);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      act_q    <= 1'b0;
      rd_phase <= 1'b0;
      wr_phase <= 1'b0;
      done     <= 1'b0;
    end else begin
      rd_phase <= 1'b0;
      wr_phase <= 1'b0;
      done     <= 1'b0;
      if (ph_q == PH_READ) begin
        ph_q     <= PH_WRITE;
        wr_phase <= act_q;
        done     <= 1'b1;
      end else if (capture) begin
        ph_q     <= PH_READ;
        act_q    <= go;
        rd_phase <= go;
      end else begin
        ph_q     <= PH_IDLE;
      end
    end
  end
endmodule

// File: rtl/ums_hold.sv
module ums_hold
  import ums_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [AW-1:0]     word_addr,
  input  logic [RIDX_W-1:0] rt_idx,
  input  logic [XLEN-1:0]   rt_val,
  input  logic              is_load,
  input  logic              is_store,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [AW-1:0]     addr_q,
  output logic [RIDX_W-1:0] rt_idx_q,
  output logic [XLEN-1:0]   mem_wdata,
  output logic [XLEN-1:0]   rf_wdata
);
  logic [XLEN-1:0] rt_val_q;
  logic            ld_q;
  logic            st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      rt_idx_q <= '0;
      rt_val_q <= '0;
      ld_q     <= 1'b0;
      st_q     <= 1'b0;
    end else if (capture) begin
      addr_q   <= word_addr;
      rt_idx_q <= rt_idx;
      rt_val_q <= rt_val;
      ld_q     <= is_load;
      st_q     <= is_store;
    end
  end

  // non-stores put back what was read; non-loads put back the old register
  assign mem_wdata = st_q ? rt_val_q : mem_rdata;
  assign rf_wdata  = ld_q ? mem_rdata : rt_val_q;
endmodule

// File: rtl/uniform_mem_stage.sv
module uniform_mem_stage
  import ums_pkg::*;
#(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [XLEN-1:0]   instr,
  input  logic              halted,
  input  logic              may_load,
  input  logic              may_store,
  output logic [RIDX_W-1:0] rf_rs_idx,
  output logic [RIDX_W-1:0] rf_rt_idx,
  input  logic [XLEN-1:0]   rf_rs_val,
  input  logic [XLEN-1:0]   rf_rt_val,
  output logic              mem_re,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_widx,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              done
);
  logic          capture;
  logic          wr_phase;
  logic          is_load;
  logic          is_store;
  logic [AW-1:0] word_addr;

  ums_decode #(.AW(AW)) u_decode (
    .instr     (instr),
    .base_val  (rf_rs_val),
    .rs_idx    (rf_rs_idx),
    .rt_idx    (rf_rt_idx),
    .is_load   (is_load),
    .is_store  (is_store),
    .word_addr (word_addr)
  );

  ums_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .halted    (halted),
    .may_load  (may_load),
    .may_store (may_store),
    .capture   (capture),
    .rd_phase  (mem_re),
    .wr_phase  (wr_phase),
    .done      (done)
  );

  ums_hold #(.AW(AW)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .word_addr (word_addr),
    .rt_idx    (rf_rt_idx),
    .rt_val    (rf_rt_val),
    .is_load   (is_load),
    .is_store  (is_store),
    .mem_rdata (mem_rdata),
    .addr_q    (mem_addr),
    .rt_idx_q  (rf_widx),
    .mem_wdata (mem_wdata),
    .rf_wdata  (rf_wdata)
  );

  // halted is honoured live in the write cycle
  assign mem_we = wr_phase && !halted;
  assign rf_we  = wr_phase && !halted && (rf_widx != '0);
endmodule

// File: rtl/uniform_mem_stage_chk.sv
module uniform_mem_stage_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       halted,
  input logic       mem_re,
  input logic       mem_we,
  input logic       rf_we,
  input logic [4:0] rf_widx,
  input logic       done
);
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(mem_re)); // R4
  AST_NO_READ_WRITE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we)); // R4
  AST_REG_WRITE_IN_MEM_SLOT: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> mem_we); // R4
  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_we && !rf_we)); // R6
  AST_ZERO_REG_KEPT: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_widx != 5'd0)); // R7
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, 2)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
endmodule

bind uniform_mem_stage uniform_mem_stage_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .halted  (halted),
  .mem_re  (mem_re),
  .mem_we  (mem_we),
  .rf_we   (rf_we),
  .rf_widx (rf_widx),
  .done    (done)
);

// File: tb/uniform_mem_stage_bench.sv
module uniform_mem_stage_bench;
  localparam int DEPTH = 1024;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [5:0] OP_LW  = 6'b100011;
  localparam logic [5:0] OP_SW  = 6'b101011;
  localparam logic [5:0] OP_ADD = 6'b000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] instr = '0;
  logic halted = 1'b0;
  logic may_load = 1'b0;
  logic may_store = 1'b0;
  logic [4:0] rf_rs_idx, rf_rt_idx, rf_widx;
  logic [31:0] rf_rs_val, rf_rt_val, mem_wdata, rf_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_re, mem_we, rf_we, done;
  logic [AW-1:0] mem_addr;

  logic [31:0] ram [DEPTH];
  logic [31:0] rf [32];

  int total = 0;
  int fails = 0;
  int rd_cnt = 0, wr_cnt = 0, rfw_cnt = 0, done_cnt = 0;

  always #10 clk = ~clk;

  uniform_mem_stage #(.DEPTH(DEPTH)) u_uniform_mem_stage (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .halted(halted),
    .may_load(may_load), .may_store(may_store),
    .rf_rs_idx(rf_rs_idx), .rf_rt_idx(rf_rt_idx),
    .rf_rs_val(rf_rs_val), .rf_rt_val(rf_rt_val),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata), .done(done)
  );

  // external models at the ports
  assign rf_rs_val = rf[rf_rs_idx];
  assign rf_rt_val = rf[rf_rt_idx];

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= ram[mem_addr];
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (rf_we && rf_widx != 5'd0) rf[rf_widx] <= rf_wdata;
    if (!rst) begin
      if (mem_re) rd_cnt <= rd_cnt + 1;
      if (mem_we) wr_cnt <= wr_cnt + 1;
      if (rf_we) rfw_cnt <= rfw_cnt + 1;
      if (done) done_cnt <= done_cnt + 1;
    end
  end

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic int waddr(logic [31:0] base, logic [15:0] imm);
    logic [31:0] ea;
    ea = base + {{16{imm[15]}}, imm};
    return int'((ea >> 2) % DEPTH);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one instruction; checks strobes and done in each of its cycles
  task automatic run(string req, logic [31:0] ins, logic ml, logic ms,
                     logic h_start, logic h_write, logic exp_rd);
    @(negedge clk);
    instr = ins; start = 1'b1; may_load = ml; may_store = ms; halted = h_start;
    @(negedge clk);
    start = 1'b0; halted = 1'b0; #1;
    chk({req, " read cycle mem_re"}, 32'(mem_re), 32'(exp_rd));
    chk({req, " read cycle done"}, 32'(done), 32'd0);
    @(negedge clk);
    halted = h_write; #1;
    chk({req, " write cycle mem_we"}, 32'(mem_we), 32'(exp_rd && !h_write));
    chk({req, " write cycle done"}, 32'(done), 32'd1);
    @(negedge clk);
    halted = 1'b0; #1;
    chk({req, " done single"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    chk("R9 mem_re", 32'(mem_re), 0);
    chk("R9 mem_we", 32'(mem_we), 0);
    chk("R9 rf_we", 32'(rf_we), 0);
    chk("R9 done", 32'(done), 0);
  endtask

  task automatic t_store();
    int a = waddr(32'h40, 16'h0008);
    run("R3 store", mk(OP_SW, 5, 6, 16'h0008), 1, 1, 0, 0, 1);
    chk("R3 ram word stored", ram[a], 32'hDEADBEEF);
    chk("R3 rt kept", rf[6], 32'hDEADBEEF);
    chk("R1 address 0x48 word", 32'(a), 32'd18);
  endtask

  task automatic t_load();
    run("R2 load", mk(OP_LW, 5, 7, 16'h0008), 1, 0, 0, 0, 1);
    chk("R2 rt loaded", rf[7], 32'hDEADBEEF);
    chk("R2 ram kept", ram[18], 32'hDEADBEEF);
  endtask

  task automatic t_neg_imm();
    ram[15] = 32'h0000_1234;
    run("R1 negative offset", mk(OP_LW, 5, 8, 16'hFFFC), 1, 1, 0, 0, 1);
    chk("R1 load from word 15", rf[8], 32'h0000_1234);
  endtask

  task automatic t_wrap();
    rf[9] = 32'd4108;
    run("R10 wrap", mk(OP_SW, 9, 6, 16'h0000), 0, 1, 0, 0, 1);
    chk("R10 wrapped to word 3", ram[3], 32'hDEADBEEF);
  endtask

  task automatic t_other_op();
    int r0 = rd_cnt, w0 = wr_cnt, f0 = rfw_cnt;
    ram[20] = 32'hA5A5_0001;
    rf[10] = 32'h0000_0123;
    run("R4 other opcode", mk(OP_ADD, 5, 10, 16'h0010), 1, 1, 0, 0, 1);
    chk("R4 one read", 32'(rd_cnt - r0), 1);
    chk("R4 one write", 32'(wr_cnt - w0), 1);
    chk("R4 one reg write", 32'(rfw_cnt - f0), 1);
    chk("R4 ram value kept", ram[20], 32'hA5A5_0001);
    chk("R4 reg value kept", rf[10], 32'h0000_0123);
  endtask

  task automatic t_skip();
    int r0 = rd_cnt, w0 = wr_cnt, f0 = rfw_cnt, d0 = done_cnt;
    rf[11] = 32'h5555_0000;
    run("R5 skip", mk(OP_LW, 5, 11, 16'h0008), 0, 0, 0, 0, 0);
    chk("R5 no read", 32'(rd_cnt - r0), 0);
    chk("R5 no write", 32'(wr_cnt - w0), 0);
    chk("R5 no reg write", 32'(rfw_cnt - f0), 0);
    chk("R5 done pulsed", 32'(done_cnt - d0), 1);
    chk("R5 reg untouched", rf[11], 32'h5555_0000);
  endtask

  task automatic t_halt_start();
    ram[21] = 32'h1111_2222;
    rf[12] = 32'h9999_0000;
    run("R6 halted at start", mk(OP_SW, 5, 12, 16'h0014), 1, 1, 1, 0, 0);
    chk("R6 ram kept (start)", ram[21], 32'h1111_2222);
  endtask

  task automatic t_halt_write();
    int f0 = rfw_cnt;
    ram[22] = 32'h3333_4444;
    run("R6 halted in write", mk(OP_SW, 5, 12, 16'h0018), 1, 1, 0, 1, 1);
    chk("R6 ram kept (write)", ram[22], 32'h3333_4444);
    chk("R6 no reg write", 32'(rfw_cnt - f0), 0);
  endtask

  task automatic t_zero_reg();
    int f0 = rfw_cnt;
    run("R7 load to r0", mk(OP_LW, 5, 0, 16'h0008), 1, 0, 0, 0, 1);
    chk("R7 no reg write", 32'(rfw_cnt - f0), 0);
    chk("R7 r0 zero", rf[0], 32'd0);
  endtask

  task automatic t_back_to_back();
    int r0 = rd_cnt, d0 = done_cnt;
    @(negedge clk);
    instr = mk(OP_SW, 5, 6, 16'h0020); start = 1'b1; may_load = 1'b1; may_store = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 two accepted reads", 32'(rd_cnt - r0), 2);
    chk("R8 two done pulses", 32'(done_cnt - d0), 2);
    chk("R8 store landed", ram[24], 32'hDEADBEEF);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ram[i] = '0;
    for (int i = 0; i < 32; i++) rf[i] = '0;
    rf[5] = 32'h40;
    rf[6] = 32'hDEADBEEF;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    t_store();
    t_load();
    t_neg_imm();
    t_wrap();
    t_other_op();
    t_skip();
    t_halt_start();
    t_halt_write();
    t_zero_reg();
    t_back_to_back();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule